// File: doc/BRIEF.md
# Cut-Through Transmit Start Controller

This block holds a byte-wide transmit FIFO that a DMA engine fills and a transmitter drains. It decides when the transmitter may begin sending the frame at the head of the queue. Sending begins when either of two things happens first. One is that the head frame has at least `threshold × 64` bytes buffered. The other is that the head frame's last byte has been written. Transmission can therefore start before the whole frame is present.

The threshold starts at 1 and moves one step at a time on up and down requests, typically after an underrun. Upward steps stop at an effective ceiling. That ceiling is the smaller of the configured maximum and the safe bound `(DEPTH − DMA request size) / 64`. The safe bound keeps the start condition reachable before the DMA side stalls for lack of space. Downward steps stop at the configured minimum, and never below 1. A refused upward step is reported. A read on an empty FIFO while a frame is in flight is flagged as an underrun.

The DMA side is told when a full request fits. Each byte carries an end-of-frame marker that travels with it through the FIFO.

Top module: `cut_thru_tx_start`

## Requirements
- R1: After reset, `thr_level` is 1, `tx_start`, `underrun` and `thr_refused` are 0, and `dma_ready` is 1 when `cfg_req_bytes` is at most DEPTH.
- R2: While the head frame is incomplete, `tx_start` rises one cycle after the write that brings that frame's written byte count (counted from its first byte) to `thr_level × 64` or more.
- R3: `tx_start` rises one cycle after the head frame's end-of-frame byte (`wr_last`=1) is written, whatever the threshold.
- R4: Once raised, `tx_start` stays high until the head frame's end-of-frame byte is read. It is 0 in the cycle after that read. One cycle later it reflects the start condition of the next frame.
- R5: Bytes and their end-of-frame markers leave in the order they were written. `rd_byte` and `rd_last` are valid in the cycle after the `rd_en` cycle.
- R6: An up request alone raises `thr_level` by one if it is below the effective ceiling. Otherwise `thr_level` is unchanged and `thr_refused` pulses for one cycle.
- R7: The effective ceiling is min(`cfg_thr_max`, (DEPTH − `cfg_req_bytes`) / 64, rounded down). It is 0 when the request size exceeds DEPTH.
- R8: A down request alone lowers `thr_level` by one if it is above the effective floor. The floor is `cfg_thr_min`, or 1 when that is 0. Otherwise `thr_level` is unchanged.
- R9: Up and down requests in the same cycle leave `thr_level` unchanged and raise no refusal.
- R10: A read request on an empty FIFO while `tx_start` is high gives a one-cycle `underrun` pulse in the next cycle. The read is ignored, so no byte is lost or skipped. With `tx_start` low, no pulse is given.
- R11: `dma_ready` is 1 exactly when DEPTH minus the occupancy is at least `cfg_req_bytes`. It follows the occupancy one cycle late.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | DMA byte write strobe |
| wr_byte | input | DW | Byte written |
| wr_last | input | 1 | Written byte ends its frame |
| dma_ready | output | 1 | Room for a full DMA request |
| rd_en | input | 1 | Transmitter read strobe |
| rd_byte | output | DW | Byte read, one cycle after rd_en |
| rd_last | output | 1 | Byte read ends its frame |
| thr_up | input | 1 | Request to raise the threshold |
| thr_down | input | 1 | Request to lower the threshold |
| cfg_thr_max | input | THR_W | Configured threshold ceiling |
| cfg_thr_min | input | THR_W | Configured threshold floor |
| cfg_req_bytes | input | CW | DMA request size in bytes |
| tx_start | output | 1 | Transmitter may send the head frame |
| underrun | output | 1 | One-cycle underrun pulse |
| thr_level | output | THR_W | Current threshold in 64-byte units |
| thr_refused | output | 1 | One-cycle pulse for a refused up request |

## Verification
The bench builds the block with its defaults: a 512-byte FIFO, 64-byte units and hence a 4-bit threshold. This small size lets it sweep every threshold from 1 to 6 with a 128-byte request size. It writes one byte at a time past each start point and checks `tx_start` and `dma_ready` after every byte. That sweep crosses the 384-byte stall point exactly. Changing the request size to 0 opens the ceiling to the full 8 units, and lowering `cfg_thr_max` below the current level exercises the refusal and the floor. Short frames, back-to-back frames and reads on an empty FIFO cover the end-of-frame start path, the re-evaluation for the next frame and the underrun pulse.

// File: rtl/cts_pkg.sv
package cts_pkg;
  // Threshold request decoded from the up/down strobes.
  typedef enum logic [1:0] {
    STEP_NONE = 2'b00,
    STEP_DOWN = 2'b01,
    STEP_UP   = 2'b10,
    STEP_BOTH = 2'b11
  } step_e;
endpackage

// File: rtl/cts_byte_fifo.sv
module cts_byte_fifo #(
  parameter int DEPTH = 512,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_req,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_eof,
  input  logic          rd_req,
  output logic [DW-1:0] rd_data,
  output logic          rd_eof,
  output logic          wr_fire,
  output logic          rd_fire,
  output logic          head_eof,
  output logic          empty,
  output logic [CW-1:0] occ
);
  logic [DW-1:0] data_mem [DEPTH];
  logic          eof_mem  [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] occ_q;
  logic          full;

  assign empty    = (occ_q == '0);
  assign full     = (occ_q == CW'(DEPTH));
  assign wr_fire  = wr_req & ~full;
  assign rd_fire  = rd_req & ~empty;
  assign occ      = occ_q;
  assign head_eof = eof_mem[rd_ptr];

  // Data array: plain synchronous write and registered read.
  always_ff @(posedge clk) begin
    if (wr_fire) begin
      data_mem[wr_ptr] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_fire) begin
      rd_data <= data_mem[rd_ptr];
    end
  end

  // Frame markers: kept apart so the head marker is visible without delay.
  always_ff @(posedge clk) begin
    if (wr_fire) begin
      eof_mem[wr_ptr] <= wr_eof;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ_q  <= '0;
      rd_eof <= 1'b0;
    end else begin
      if (wr_fire) wr_ptr <= wr_ptr + 1'b1;
      if (rd_fire) begin
        rd_ptr <= rd_ptr + 1'b1;
        rd_eof <= eof_mem[rd_ptr];
      end
      case ({wr_fire, rd_fire})
        2'b10:   occ_q <= occ_q + 1'b1;
        2'b01:   occ_q <= occ_q - 1'b1;
        default: occ_q <= occ_q;
      endcase
    end
  end

  a_r11_occ_bound: assert property (@(posedge clk) disable iff (rst)
    occ_q <= CW'(DEPTH));

  a_r10_no_read_when_empty: assert property (@(posedge clk) disable iff (rst)
    (rd_req && empty && !wr_req) |=> $stable(rd_ptr));
endmodule

// File: rtl/cts_thresh_ctrl.sv
module cts_thresh_ctrl
  import cts_pkg::*;
#(
  parameter int DEPTH     = 512,
  parameter int UNIT_LOG2 = 6,
  parameter int CW        = 10,
  parameter int THR_W     = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             up_req,
  input  logic             down_req,
  input  logic [THR_W-1:0] cfg_max,
  input  logic [THR_W-1:0] cfg_min,
  input  logic [CW-1:0]    cfg_req,
  output logic [THR_W-1:0] thr,
  output logic             refused
);
  logic [CW-1:0]    headroom, safe_units, max_ext;
  logic [THR_W-1:0] eff_max, eff_min;
  step_e            step;

  always_comb begin
    headroom   = (cfg_req >= CW'(DEPTH)) ? '0 : (CW'(DEPTH) - cfg_req);
    safe_units = headroom >> UNIT_LOG2;
    max_ext    = CW'(cfg_max);
    eff_max    = THR_W'((max_ext < safe_units) ? max_ext : safe_units);
    eff_min    = (cfg_min == '0) ? THR_W'(1) : cfg_min;
    step       = step_e'({up_req, down_req});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      thr     <= THR_W'(1);
      refused <= 1'b0;
    end else begin
      refused <= 1'b0;
      unique case (step)
        STEP_UP: begin
          if (thr < eff_max) thr <= thr + 1'b1;
          else               refused <= 1'b1;
        end
        STEP_DOWN: begin
          if (thr > eff_min) thr <= thr - 1'b1;
        end
        default: thr <= thr;
      endcase
    end
  end

  a_r6_up_steps_one: assert property (@(posedge clk) disable iff (rst)
    (up_req && !down_req && thr < eff_max) |=> (thr == $past(thr) + 1'b1));

  a_r6_refusal_keeps_level: assert property (@(posedge clk) disable iff (rst)
    refused |-> $stable(thr));

  a_r8_floor_holds: assert property (@(posedge clk) disable iff (rst)
    (down_req && !up_req && thr <= eff_min) |=> $stable(thr));

  a_r9_both_ignored: assert property (@(posedge clk) disable iff (rst)
    (up_req && down_req) |=> ($stable(thr) && !refused));
endmodule

// File: rtl/cts_start_logic.sv
module cts_start_logic #(
  parameter int CW        = 10,
  parameter int THR_W     = 4,
  parameter int UNIT_LOG2 = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_fire,
  input  logic             wr_eof,
  input  logic             rd_fire,
  input  logic             rd_req,
  input  logic             head_eof,
  input  logic             empty,
  input  logic [THR_W-1:0] thr,
  output logic             tx_start,
  output logic             underrun
);
  logic [CW-1:0] whole_frames;   // frames fully written, not fully read
  logic [CW-1:0] open_bytes;     // bytes written of the frame still open
  logic [CW-1:0] thr_bytes;
  logic          head_ready;
  logic          eof_read;
  logic          started_q;

  assign thr_bytes  = CW'(thr) << UNIT_LOG2;
  assign head_ready = (whole_frames != '0) || (open_bytes >= thr_bytes);
  assign eof_read   = rd_fire & head_eof;
  assign tx_start   = started_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      whole_frames <= '0;
      open_bytes   <= '0;
    end else begin
      case ({wr_fire & wr_eof, eof_read})
        2'b10:   whole_frames <= whole_frames + 1'b1;
        2'b01:   whole_frames <= whole_frames - 1'b1;
        default: whole_frames <= whole_frames;
      endcase
      if (wr_fire) begin
        if (wr_eof)               open_bytes <= '0;
        else if (open_bytes != '1) open_bytes <= open_bytes + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      started_q <= 1'b0;
      underrun  <= 1'b0;
    end else begin
      if (eof_read)        started_q <= 1'b0;
      else if (head_ready) started_q <= 1'b1;
      underrun <= rd_req & empty & started_q;
    end
  end

  a_r4_drop_only_on_eof: assert property (@(posedge clk) disable iff (rst)
    $fell(started_q) |-> $past(eof_read));

  a_r10_underrun_needs_empty: assert property (@(posedge clk) disable iff (rst)
    underrun |-> ($past(empty) && $past(rd_req)));

  a_r3_complete_frame_starts: assert property (@(posedge clk) disable iff (rst)
    (whole_frames != '0 && !eof_read) |=> started_q);
endmodule

// File: rtl/cut_thru_tx_start.sv
module cut_thru_tx_start #(
  parameter int DEPTH      = 512,
  parameter int DW         = 8,
  parameter int UNIT_LOG2  = 6,
  localparam int CW        = $clog2(DEPTH) + 1,
  localparam int THR_W     = $clog2((DEPTH >> UNIT_LOG2) + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [DW-1:0]    wr_byte,
  input  logic             wr_last,
  output logic             dma_ready,
  input  logic             rd_en,
  output logic [DW-1:0]    rd_byte,
  output logic             rd_last,
  input  logic             thr_up,
  input  logic             thr_down,
  input  logic [THR_W-1:0] cfg_thr_max,
  input  logic [THR_W-1:0] cfg_thr_min,
  input  logic [CW-1:0]    cfg_req_bytes,
  output logic             tx_start,
  output logic             underrun,
  output logic [THR_W-1:0] thr_level,
  output logic             thr_refused
);
  logic          wr_fire, rd_fire, head_eof, empty;
  logic [CW-1:0] occ;

  cts_byte_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
    .clk      (clk),
    .rst      (rst),
    .wr_req   (wr_en),
    .wr_data  (wr_byte),
    .wr_eof   (wr_last),
    .rd_req   (rd_en),
    .rd_data  (rd_byte),
    .rd_eof   (rd_last),
    .wr_fire  (wr_fire),
    .rd_fire  (rd_fire),
    .head_eof (head_eof),
    .empty    (empty),
    .occ      (occ)
  );

  cts_thresh_ctrl #(
    .DEPTH(DEPTH), .UNIT_LOG2(UNIT_LOG2), .CW(CW), .THR_W(THR_W)
  ) u_thresh (
    .clk      (clk),
    .rst      (rst),
    .up_req   (thr_up),
    .down_req (thr_down),
    .cfg_max  (cfg_thr_max),
    .cfg_min  (cfg_thr_min),
    .cfg_req  (cfg_req_bytes),
    .thr      (thr_level),
    .refused  (thr_refused)
  );

  cts_start_logic #(
    .CW(CW), .THR_W(THR_W), .UNIT_LOG2(UNIT_LOG2)
  ) u_start (
    .clk      (clk),
    .rst      (rst),
    .wr_fire  (wr_fire),
    .wr_eof   (wr_last),
    .rd_fire  (rd_fire),
    .rd_req   (rd_en),
    .head_eof (head_eof),
    .empty    (empty),
    .thr      (thr_level),
    .tx_start (tx_start),
    .underrun (underrun)
  );

  always_ff @(posedge clk) begin
    if (rst) dma_ready <= 1'b1;
    else     dma_ready <= ((CW'(DEPTH) - occ) >= cfg_req_bytes);
  end

  a_r11_ready_means_room: assert property (@(posedge clk) disable iff (rst)
    (dma_ready && $stable(occ) && $stable(cfg_req_bytes))
      |-> ((CW'(DEPTH) - occ) >= cfg_req_bytes));
endmodule

// File: tb/cut_thru_tx_start_tb.sv
module cut_thru_tx_start_tb_top;
  localparam int DEPTH = 512;
  localparam int DW    = 8;
  localparam int UNIT  = 6;
  localparam int CW    = 10;
  localparam int THR_W = 4;

  logic clk, rst;
  logic wr_en, wr_last, rd_en, thr_up, thr_down;
  logic [DW-1:0] wr_byte, rd_byte;
  logic rd_last, dma_ready, tx_start, underrun, thr_refused;
  logic [THR_W-1:0] cfg_thr_max, cfg_thr_min, thr_level;
  logic [CW-1:0] cfg_req_bytes;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  cut_thru_tx_start #(.DEPTH(DEPTH), .DW(DW), .UNIT_LOG2(UNIT)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_byte(wr_byte), .wr_last(wr_last),
    .dma_ready(dma_ready), .rd_en(rd_en), .rd_byte(rd_byte), .rd_last(rd_last),
    .thr_up(thr_up), .thr_down(thr_down), .cfg_thr_max(cfg_thr_max),
    .cfg_thr_min(cfg_thr_min), .cfg_req_bytes(cfg_req_bytes),
    .tx_start(tx_start), .underrun(underrun), .thr_level(thr_level),
    .thr_refused(thr_refused));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [7:0] pat(int f, int i);
    return 8'((f * 37 + i * 5 + 3) & 255);
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Write one byte; returns after start logic has seen the new count.
  task automatic wr1(logic [7:0] d, logic l);
    @(negedge clk); wr_en = 1'b1; wr_byte = d; wr_last = l;
    @(negedge clk); wr_en = 1'b0; wr_last = 1'b0;
    @(negedge clk);
  endtask

  // Read one byte; returns when rd_byte/rd_last/underrun are valid.
  task automatic rd1();
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic step(logic up, logic dn);
    @(negedge clk); thr_up = up; thr_down = dn;
    @(negedge clk); thr_up = 1'b0; thr_down = 1'b0;
  endtask

  task automatic read_frame(int f, int len, string tag);
    for (int i = 0; i < len; i++) begin
      rd1();
      chk({tag, " R5 data"}, int'(rd_byte), int'(pat(f, i)));
      chk({tag, " R5 last"}, int'(rd_last), (i == len - 1) ? 1 : 0);
      chk({tag, " R4 hold/drop"}, int'(tx_start), (i == len - 1) ? 0 : 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_byte = '0; wr_last = 1'b0; rd_en = 1'b0;
    thr_up = 1'b0; thr_down = 1'b0;
    cfg_thr_max = 4'd10; cfg_thr_min = 4'd1; cfg_req_bytes = 10'd128;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 thr", int'(thr_level), 1);
    chk("R1 start", int'(tx_start), 0);
    chk("R1 underrun", int'(underrun), 0);
    chk("R1 refused", int'(thr_refused), 0);
    chk("R1 ready", int'(dma_ready), 1);

    // Sweep every threshold reachable with 128-byte requests.
    for (int t = 1; t <= 6; t++) begin
      int len;
      if (t > 1) begin
        step(1'b1, 1'b0);
        chk("R6 up", int'(thr_level), t);
        chk("R6 no refusal", int'(thr_refused), 0);
      end
      len = t * 64 + 3;
      for (int k = 1; k <= len - 1; k++) begin
        wr1(pat(t, k - 1), 1'b0);
        chk("R2 start point", int'(tx_start), (k >= t * 64) ? 1 : 0);
        chk("R11 ready", int'(dma_ready), ((DEPTH - k) >= 128) ? 1 : 0);
      end
      wr1(pat(t, len - 1), 1'b1);
      chk("R3 start", int'(tx_start), 1);
      read_frame(t, len, "sweep");
      @(negedge clk);
      chk("R4 empty stays low", int'(tx_start), 0);
    end

    step(1'b1, 1'b0);
    chk("R7 ceiling 6 level", int'(thr_level), 6);
    chk("R6 refused", int'(thr_refused), 1);
    @(negedge clk);
    chk("R6 refusal one cycle", int'(thr_refused), 0);

    cfg_req_bytes = 10'd0; cfg_thr_max = 4'd15;
    step(1'b1, 1'b0); chk("R7 up to 7", int'(thr_level), 7);
    step(1'b1, 1'b0); chk("R7 up to 8", int'(thr_level), 8);
    step(1'b1, 1'b0);
    chk("R7 ceiling 8 level", int'(thr_level), 8);
    chk("R7 ceiling 8 refused", int'(thr_refused), 1);

    cfg_thr_max = 4'd3;
    step(1'b1, 1'b0);
    chk("R6 above max level", int'(thr_level), 8);
    chk("R6 above max refused", int'(thr_refused), 1);

    cfg_req_bytes = 10'd600; cfg_thr_max = 4'd15;
    step(1'b1, 1'b0);
    chk("R7 oversize request refused", int'(thr_refused), 1);
    cfg_req_bytes = 10'd128; cfg_thr_max = 4'd10;

    cfg_thr_min = 4'd2;
    for (int v = 7; v >= 2; v--) begin
      step(1'b0, 1'b1);
      chk("R8 down", int'(thr_level), v);
    end
    step(1'b0, 1'b1); chk("R8 floor 2", int'(thr_level), 2);
    cfg_thr_min = 4'd0;
    step(1'b0, 1'b1); chk("R8 down to 1", int'(thr_level), 1);
    step(1'b0, 1'b1); chk("R8 floor 1", int'(thr_level), 1);

    step(1'b1, 1'b1);
    chk("R9 both level", int'(thr_level), 1);
    chk("R9 both no refusal", int'(thr_refused), 0);
    step(1'b1, 1'b0); chk("R6 up to 2", int'(thr_level), 2);
    step(1'b1, 1'b1); chk("R9 both at 2", int'(thr_level), 2);

    // Short frames start on their end-of-frame byte.
    for (int s = 0; s < 3; s++) begin
      int len;
      len = (s == 0) ? 1 : ((s == 1) ? 5 : 63);
      for (int i = 0; i < len - 1; i++) wr1(pat(20 + s, i), 1'b0);
      chk("R3 not yet", int'(tx_start), 0);
      wr1(pat(20 + s, len - 1), 1'b1);
      chk("R3 start on eof", int'(tx_start), 1);
      read_frame(20 + s, len, "short");
    end

    // Two frames: second incomplete, below threshold.
    for (int i = 0; i < 10; i++) wr1(pat(30, i), (i == 9) ? 1'b1 : 1'b0);
    for (int i = 0; i < 5; i++) wr1(pat(31, i), 1'b0);
    chk("R3 two frames", int'(tx_start), 1);
    read_frame(30, 10, "pair");
    @(negedge clk);
    chk("R4 next below thr", int'(tx_start), 0);
    for (int i = 5; i < 128; i++) wr1(pat(31, i), 1'b0);
    chk("R2 next reaches thr", int'(tx_start), 1);
    wr1(pat(31, 128), 1'b1);
    read_frame(31, 129, "pair2");

    // Two complete frames: restart one cycle after the first eof read.
    for (int i = 0; i < 4; i++) wr1(pat(40, i), (i == 3) ? 1'b1 : 1'b0);
    for (int i = 0; i < 3; i++) wr1(pat(41, i), (i == 2) ? 1'b1 : 1'b0);
    read_frame(40, 4, "b2b");
    @(negedge clk);
    chk("R4 restart next frame", int'(tx_start), 1);
    read_frame(41, 3, "b2b2");

    // Underrun.
    rd1();
    chk("R10 idle no pulse", int'(underrun), 0);
    step(1'b0, 1'b1); chk("R8 back to 1", int'(thr_level), 1);
    for (int i = 0; i < 64; i++) wr1(pat(50, i), 1'b0);
    chk("R2 64 bytes", int'(tx_start), 1);
    for (int i = 0; i < 64; i++) begin
      rd1();
      chk("R5 data", int'(rd_byte), int'(pat(50, i)));
      chk("R10 no pulse", int'(underrun), 0);
    end
    chk("R4 still high", int'(tx_start), 1);
    rd1();
    chk("R10 pulse", int'(underrun), 1);
    @(negedge clk);
    chk("R10 one cycle", int'(underrun), 0);
    wr1(8'hA5, 1'b1);
    rd1();
    chk("R10 read ignored data", int'(rd_byte), 8'hA5);
    chk("R10 read ignored last", int'(rd_last), 1);
    chk("R4 drop after eof", int'(tx_start), 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule